// File: doc/BRIEF.md
# E1 Receive Rail Decoder

This block sits behind the line slicer of an E1 receiver. The slicer reports positive and negative line pulses, and the block samples them on the recovered clock. It turns them into NRZ data in one of two forms, picked by a static rail-mode input.

In single-rail form, marks of either polarity merge into one unipolar data bit. An optional HDB3 decoder removes the zero-substitution codes. A violation flag travels with the data, aligned to the bit it describes. This path always has the same four-cycle latency, so switching between AMI and HDB3 does not move the data in time.

In dual-rail form, the two pulse streams pass through as separate p-rail and n-rail NRZ outputs after one register. The violation flag and the unipolar data are held at zero. A polarity input can invert the forwarded clock and make both rails active-low. Static control inputs are meant to change only while reset is asserted, with one exception: entering dual-rail mode clears the single-rail pipeline within one cycle.

Top module: `e1_rx_rail_decoder`

## Requirements
- R1: With all controls at 0 (single-rail, AMI), `sr_data` equals `pos_pulse | neg_pulse` sampled exactly four clock cycles earlier.
- R2: In single-rail mode, a single-rail mark whose polarity equals that of the previous single-rail mark raises `viol` in the same output cycle as that mark (`viol` is only ever set with `sr_data`). The first mark after reset is never flagged. Spaces between marks do not matter.
- R3: Both pulse inputs high in the same cycle count as a mark with `viol` set. Such a mark does not change the stored polarity.
- R4: With `hdb3_en`=1, a polarity violation that follows three decoded zeros is output as a zero with `viol`=0.
- R5: With `hdb3_en`=1, a violation whose preceding three decoded bits are unflagged mark, zero, zero (B00V) makes both the B and the V output as zeros with `viol`=0. A legally HDB3-encoded stream therefore decodes to its source bits.
- R6: With `hdb3_en`=1, a polarity violation that matches neither pattern is output as a mark with `viol`=1. The latency stays four cycles.
- R7: With `dual_rail`=1 and `inv_logic`=0, `rp_data` and `rn_data` equal `pos_pulse` and `neg_pulse` from one cycle earlier, and `rclk_out` follows `clk`.
- R8: With `dual_rail`=1, `sr_data` and `viol` are 0 from the first clock edge that samples the mode onward.
- R9: With `dual_rail`=1 and `inv_logic`=1, `rclk_out` is the inverse of `clk`, and each rail output is the inverse of its pulse input from one cycle earlier.
- R10: With `dual_rail`=0, `rp_data` and `rn_data` are 0 and `rclk_out` follows `clk`, whatever the value of `inv_logic`.
- R11: While `rst` is high at a clock edge, all registered outputs become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered line clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_pulse | input | 1 | Positive pulse seen in this bit period |
| neg_pulse | input | 1 | Negative pulse seen in this bit period |
| dual_rail | input | 1 | 0 = unipolar output, 1 = separate p/n rails |
| hdb3_en | input | 1 | 1 = HDB3 decoding in single-rail mode |
| inv_logic | input | 1 | 1 = inverted clock and active-low rails in dual-rail mode |
| sr_data | output | 1 | Unipolar NRZ data (single-rail) |
| viol | output | 1 | Line-code violation, aligned with `sr_data` |
| rp_data | output | 1 | Positive-rail NRZ data (dual-rail) |
| rn_data | output | 1 | Negative-rail NRZ data (dual-rail) |
| rclk_out | output | 1 | Forwarded clock, inverted in active-low dual-rail mode |

## Verification
The hardest case to reach is a B00V substitution. It needs a run of four zeros after an even number of marks since the last substitution, and the B must land exactly three slots before a same-polarity pulse. Random raw pulses almost never produce it. The bench therefore draws random source bits with many zeros and encodes them with its own HDB3 encoder. This produces both substitution kinds many times, and the decoded output is compared directly against the source bits. Raw random pulses, including both-rail cycles, cover the unmatched-violation and AMI cases against a bench model.

// File: rtl/e1rd_pkg.sv
package e1rd_pkg;
  // HDB3 substitution codes span four bit periods
  localparam int unsigned HDB3_SPAN = 4;

  typedef enum logic {
    POL_NEG = 1'b0,
    POL_POS = 1'b1
  } e1rd_pol_e;
endpackage

// File: rtl/e1rd_pol_track.sv
module e1rd_pol_track
  import e1rd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic pos_in,
  input  logic neg_in,
  output logic any_mark,
  output logic both_rails,
  output logic bipolar_viol
);
  e1rd_pol_e last_q;
  logic      seen_q;
  logic      one_rail;
  e1rd_pol_e cur_pol;

  always_comb begin
    one_rail     = pos_in ^ neg_in;
    cur_pol      = pos_in ? POL_POS : POL_NEG;
    any_mark     = enable & (pos_in | neg_in);
    both_rails   = enable & pos_in & neg_in;
    bipolar_viol = enable & one_rail & seen_q & (cur_pol == last_q);
  end

  // polarity of the latest single-rail mark; cleared outside single-rail mode
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      seen_q <= 1'b0;
      last_q <= POL_NEG;
    end else if (one_rail) begin
      seen_q <= 1'b1;
      last_q <= cur_pol;
    end
  end
endmodule

// File: rtl/e1rd_sr_pipe.sv
module e1rd_sr_pipe
  import e1rd_pkg::*;
#(
  parameter int unsigned DEPTH = HDB3_SPAN
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic hdb3_en,
  input  logic any_mark,
  input  logic both_rails,
  input  logic bipolar_viol,
  output logic sr_data,
  output logic viol
);
  // stage holding the candidate B bit when a V arrives
  localparam int B_STG = int'(HDB3_SPAN) - 2;

  logic [DEPTH-1:0] mark_q;
  logic [DEPTH-1:0] flag_q;
  logic gap_clear;
  logic sub_hit;
  logic drop_b;

  always_comb begin
    gap_clear = ~|mark_q[B_STG-1:0];
    sub_hit   = hdb3_en & bipolar_viol & gap_clear & ~flag_q[B_STG];
    drop_b    = sub_hit & mark_q[B_STG];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      mark_q <= '0;
      flag_q <= '0;
    end else begin
      mark_q[0] <= any_mark & ~sub_hit;
      flag_q[0] <= (bipolar_viol | both_rails) & ~sub_hit;
      for (int i = 1; i < int'(DEPTH); i++) begin
        if (i == B_STG + 1) mark_q[i] <= mark_q[i-1] & ~drop_b;
        else                mark_q[i] <= mark_q[i-1];
        flag_q[i] <= flag_q[i-1];
      end
    end
  end

  assign sr_data = mark_q[DEPTH-1];
  assign viol    = flag_q[DEPTH-1];

  // R2: a flagged output bit is always a mark
  p_viol_marks_r2: assert property (@(posedge clk) disable iff (rst)
    viol |-> sr_data);

  // R1: without HDB3 no mark is lost between the last two stages
  p_ami_keeps_marks_r1: assert property (@(posedge clk) disable iff (rst)
    (!hdb3_en && !flush && mark_q[DEPTH-2]) |=> mark_q[DEPTH-1]);

  // R4: a recognised substitution enters the pipe silent
  p_sub_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (sub_hit && !flush) |=> (!mark_q[0] && !flag_q[0]));

  // R8: flushing empties the output stage
  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!sr_data && !viol));
endmodule

// File: rtl/e1rd_dr_out.sv
module e1rd_dr_out (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic inv,
  input  logic pos_in,
  input  logic neg_in,
  output logic rp_data,
  output logic rn_data,
  output logic rclk_out
);
  logic low_act;

  assign low_act  = enable & inv;
  assign rclk_out = clk ^ low_act;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      rp_data <= 1'b0;
      rn_data <= 1'b0;
    end else begin
      rp_data <= pos_in ^ inv;
      rn_data <= neg_in ^ inv;
    end
  end

  p_rail_true_r7: assert property (@(posedge clk) disable iff (rst)
    (enable && !inv) |=> (rp_data == $past(pos_in) && rn_data == $past(neg_in)));

  p_rail_low_r9: assert property (@(posedge clk) disable iff (rst)
    (enable && inv) |=> (rp_data == !$past(pos_in) && rn_data == !$past(neg_in)));

  p_rail_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!rp_data && !rn_data));
endmodule

// File: rtl/e1_rx_rail_decoder.sv
module e1_rx_rail_decoder
  import e1rd_pkg::*;
#(
  parameter int unsigned SR_LATENCY = HDB3_SPAN
) (
  input  logic clk,
  input  logic rst,
  input  logic pos_pulse,
  input  logic neg_pulse,
  input  logic dual_rail,
  input  logic hdb3_en,
  input  logic inv_logic,
  output logic sr_data,
  output logic viol,
  output logic rp_data,
  output logic rn_data,
  output logic rclk_out
);
  logic any_mark;
  logic both_rails;
  logic bipolar_viol;

  e1rd_pol_track u_pol (
    .clk          (clk),
    .rst          (rst),
    .enable       (!dual_rail),
    .pos_in       (pos_pulse),
    .neg_in       (neg_pulse),
    .any_mark     (any_mark),
    .both_rails   (both_rails),
    .bipolar_viol (bipolar_viol)
  );

  e1rd_sr_pipe #(.DEPTH(SR_LATENCY)) u_pipe (
    .clk          (clk),
    .rst          (rst),
    .flush        (dual_rail),
    .hdb3_en      (hdb3_en),
    .any_mark     (any_mark),
    .both_rails   (both_rails),
    .bipolar_viol (bipolar_viol),
    .sr_data      (sr_data),
    .viol         (viol)
  );

  e1rd_dr_out u_dr (
    .clk      (clk),
    .rst      (rst),
    .enable   (dual_rail),
    .inv      (inv_logic),
    .pos_in   (pos_pulse),
    .neg_in   (neg_pulse),
    .rp_data  (rp_data),
    .rn_data  (rn_data),
    .rclk_out (rclk_out)
  );

  // R8: no violation is reported once dual-rail mode has been sampled
  p_viol_off_dual_r8: assert property (@(posedge clk) disable iff (rst)
    dual_rail |=> !viol);
endmodule

// File: tb/e1_rx_rail_decoder_bench.sv
module e1_rx_rail_decoder_bench;
  localparam int LEN = 800;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, pos = 1'b0, neg = 1'b0;
  logic dual_rail = 1'b0, hdb3_en = 1'b0, inv_logic = 1'b0;
  logic sr_data, viol, rp_data, rn_data, rclk_out;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic m_dec [0:4095];
  logic m_flg [0:4095];
  int   m_k;
  logic m_seen, m_last;
  logic src   [0:4095];
  logic enc_p [0:4095];
  logic enc_n [0:4095];

  e1_rx_rail_decoder u_e1_rx_rail_decoder (
    .clk(clk), .rst(rst), .pos_pulse(pos), .neg_pulse(neg),
    .dual_rail(dual_rail), .hdb3_en(hdb3_en), .inv_logic(inv_logic),
    .sr_data(sr_data), .viol(viol), .rp_data(rp_data), .rn_data(rn_data),
    .rclk_out(rclk_out)
  );

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic dec_at(int i);
    return (i < 0) ? 1'b0 : m_dec[i];
  endfunction

  function automatic logic flg_at(int i);
    return (i < 0) ? 1'b0 : m_flg[i];
  endfunction

  // reference decoder built from R1-R6 wording
  task automatic model_push(logic p, logic n);
    logic mark, both, bpv, d, f;
    mark = p | n;
    both = p & n;
    bpv  = mark && !both && m_seen && (p == m_last);
    if (mark && !both) begin
      m_seen = 1'b1;
      m_last = p;
    end
    d = mark;
    f = bpv | both;
    if (hdb3_en && bpv && !dec_at(m_k-1) && !dec_at(m_k-2) && !flg_at(m_k-3)) begin
      if (m_k >= 3) m_dec[m_k-3] = 1'b0;
      d = 1'b0;
      f = 1'b0;
    end
    m_dec[m_k] = d;
    m_flg[m_k] = f;
    m_k++;
  endtask

  task automatic restart(logic dr, logic hd, logic iv);
    rst = 1'b1; pos = 1'b0; neg = 1'b0;
    dual_rail = dr; hdb3_en = hd; inv_logic = iv;
    repeat (2) @(negedge clk);
    #1;
    rst = 1'b0;
    m_k = 0; m_seen = 1'b0; m_last = 1'b0;
  endtask

  task automatic step(logic p, logic n, string req);
    int j;
    pos = p; neg = n;
    if (!dual_rail) model_push(p, n);
    @(negedge clk);
    #1;
    if (!dual_rail) begin
      j = m_k - 4;
      check(req, sr_data, dec_at(j));
      check(req, viol, flg_at(j));
      check("R10 rp idle", rp_data, 1'b0);
      check("R10 rn idle", rn_data, 1'b0);
      check("R10 clock", rclk_out, 1'b0);
    end else begin
      check(req, rp_data, p ^ inv_logic);
      check(req, rn_data, n ^ inv_logic);
      check("R8 data", sr_data, 1'b0);
      check("R8 viol", viol, 1'b0);
      check(inv_logic ? "R9 clock" : "R7 clock", rclk_out, inv_logic);
    end
  endtask

  task automatic rand_step(string req);
    int r;
    r = int'($urandom % 8);
    step(r == 1 || r == 2 || r == 7, r == 3 || r == 4 || r == 7, req);
  endtask

  // bench HDB3 encoder over src[0:len-1]
  task automatic build_hdb3(int len);
    int i, cnt;
    logic lastp, b;
    for (int k = 0; k < len; k++) src[k] = (($urandom % 3) == 0);
    i = 0; cnt = 0; lastp = 1'b0;
    while (i < len) begin
      if (i + 3 < len && !src[i] && !src[i+1] && !src[i+2] && !src[i+3]) begin
        for (int k = 0; k < 4; k++) begin enc_p[i+k] = 1'b0; enc_n[i+k] = 1'b0; end
        if (cnt % 2 == 1) begin
          enc_p[i+3] = lastp; enc_n[i+3] = !lastp;
        end else begin
          b = !lastp;
          enc_p[i] = b; enc_n[i] = !b;
          enc_p[i+3] = b; enc_n[i+3] = !b;
          lastp = b;
        end
        cnt = 0;
        i += 4;
      end else begin
        if (src[i]) begin
          lastp = !lastp;
          enc_p[i] = lastp; enc_n[i] = !lastp;
          cnt++;
        end else begin
          enc_p[i] = 1'b0; enc_n[i] = 1'b0;
        end
        i++;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R11: reset state
    repeat (2) @(negedge clk);
    #1;
    check("R11 sr_data", sr_data, 1'b0);
    check("R11 viol", viol, 1'b0);
    check("R11 rp", rp_data, 1'b0);
    check("R11 rn", rn_data, 1'b0);

    // R1 R2 R3 directed AMI
    restart(1'b0, 1'b0, 1'b0);
    step(1,0,"R1"); step(0,0,"R1"); step(0,1,"R1"); step(1,0,"R2");
    step(0,0,"R2"); step(1,0,"R2"); step(1,1,"R3"); step(0,1,"R3");
    step(0,1,"R2");
    repeat (4) step(0,0,"R1");

    // R4 directed 000V
    restart(1'b0, 1'b1, 1'b0);
    step(1,0,"R4"); step(0,0,"R4"); step(0,0,"R4"); step(0,0,"R4");
    step(1,0,"R4"); step(0,1,"R4");
    repeat (4) step(0,0,"R4");

    // R5 directed B00V
    restart(1'b0, 1'b1, 1'b0);
    step(1,0,"R5"); step(0,1,"R5"); step(1,0,"R5"); step(0,0,"R5");
    step(0,0,"R5"); step(1,0,"R5");
    repeat (4) step(0,0,"R5");

    // R6 directed unmatched violation
    restart(1'b0, 1'b1, 1'b0);
    step(1,0,"R6"); step(0,0,"R6"); step(1,0,"R6"); step(1,1,"R6");
    repeat (4) step(0,0,"R6");

    // R5 encoded random stream must decode to its source
    build_hdb3(LEN);
    restart(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < LEN; i++) begin
      step(enc_p[i], enc_n[i], "R4 R5");
      if (i >= 3) begin
        check("R5 source bit", sr_data, src[i-3]);
        check("R5 no viol", viol, 1'b0);
      end
    end

    // R6 random raw pulses with HDB3
    restart(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < LEN; i++) rand_step("R6");

    // R1 R2 R3 random raw pulses in AMI
    restart(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < LEN; i++) rand_step("R2 R3");

    // R10 single-rail ignores inv_logic
    restart(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 200; i++) rand_step("R10");

    // R7 dual-rail true polarity
    restart(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 300; i++) rand_step("R7");

    // R9 dual-rail active-low
    restart(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 300; i++) rand_step("R9");

    // R8 switching into dual-rail flushes the unipolar path
    restart(1'b0, 1'b0, 1'b0);
    step(1,0,"R1"); step(1,0,"R2"); step(0,1,"R1"); step(1,1,"R3");
    dual_rail = 1'b1;
    step(0,0,"R8");
    step(1,0,"R8");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule